// File: doc/BRIEF.md
# Instruction Address Sequencer with Two-Level Return Stack

This block produces the instruction fetch address for a small core whose instructions are 12 bits wide. It keeps a 12-bit program counter over a logical space of 2K words. The program store behind it has only 1K physical words, so the address sent to the store is the low ten bits of the counter, and any counter value above 3FFh folds back into the first 1K. The instruction decoder drives one-cycle strobes: advance, branch, subroutine call and subroutine return. It also supplies a target field. A page bit taken from the status register provides counter bit 9 for branches and calls.

Return addresses live in a hardware stack with exactly two levels and no overflow detection. The highest physical word holds the oscillator calibration constant. The block raises a flag whenever the fetch address points at that word. It also gates a write side port so that a write aimed at that word is never granted.

Top module: `insn_addr_seq`

## Requirements
- R1: When rst is high at a clock edge, pc_o becomes 000h and both return stack levels become 000h. A return issued straight after reset therefore yields 000h.
- R2: With only step_i set, pc_o advances by one, modulo 2048. 7FFh becomes 000h, and pc_o bit 11 is always 0.
- R3: fetch_addr_o always equals pc_o bits 9:0, so counter values above 3FFh wrap into the 1K physical space.
- R4: A branch (jump_i as the highest active strobe) loads pc_o with bits 11:10 = 0, bit 9 = page_i and bits 8:0 = target_i.
- R5: A call loads pc_o with bits 11:10 = 0, bit 9 = page_i, bit 8 = 0 and bits 7:0 = target_i bits 7:0. target_i bit 8 has no effect.
- R6: A call pushes the old counter plus one (modulo 2048) into stack level 1 and moves the old level 1 into level 2.
- R7: A third call with no return in between discards the oldest entry. Three returns then yield the third, the second and again the second return address.
- R8: A return loads pc_o from level 1 and copies level 2 into level 1. Level 2 keeps its value, so repeated returns keep yielding it.
- R9: When several strobes are active in one cycle, the priority is rst, then ret_i, then call_i, then jump_i, then step_i. Strobes of lower priority have no effect, and a return together with a call does not push.
- R10: cal_word_o is 1 exactly when fetch_addr_o is 3FFh, including when pc_o is 7FFh.
- R11: wr_grant_o is combinationally wr_req_i AND (wr_addr_i != 3FFh).
- R12: When no strobe is active, pc_o and the stack hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the counter by one |
| jump_i | input | 1 | Branch to a target in the page |
| call_i | input | 1 | Call a subroutine, pushing the return address |
| ret_i | input | 1 | Return from a subroutine, popping the stack |
| target_i | input | 9 | Target field from the decoder |
| page_i | input | 1 | Page select bit from the status register |
| wr_req_i | input | 1 | Program store write request |
| wr_addr_i | input | 10 | Program store write address |
| pc_o | output | 12 | Program counter |
| fetch_addr_o | output | 10 | Physical fetch address |
| cal_word_o | output | 1 | Fetch address points at the calibration word |
| wr_grant_o | output | 1 | Write request allowed |

## Verification
A corrupted counter shows on pc_o and fetch_addr_o at the very next edge, because both are compared against an arithmetic model after every cycle. A corrupted stack entry stays hidden until it is popped. For that reason the bench runs call and return chains, including an overflow by three calls, so that a bad level 1 or level 2 appears on pc_o within one to three returns. Full sweeps of the counter, of the branch targets in both pages and of the write address cover every wrap and every calibration-word case.

// File: rtl/insn_addr_pkg.sv
package insn_addr_pkg;
    localparam int PC_W     = 12;
    localparam int LOG_W    = 11;
    localparam int PHYS_W   = 10;
    localparam int TGT_W    = 9;
    localparam int CALL_W   = 8;
    localparam int PAGE_BIT = 9;
    localparam int STK_LVLS = 2;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [TGT_W-1:0]  tgt_t;

    localparam pc_t   LOG_MASK = pc_t'((1 << LOG_W) - 1);
    localparam phys_t CAL_ADDR = '1;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_STEP,
        SEL_JUMP,
        SEL_CALL,
        SEL_RET
    } pc_sel_e;

    typedef struct packed {
        logic step;
        logic jump;
        logic call;
        logic ret;
    } strobe_t;

    function automatic pc_t wrap_inc(input pc_t v);
        return (v + pc_t'(1)) & LOG_MASK;
    endfunction

    function automatic pc_t jump_dest(input logic page, input tgt_t t);
        pc_t r;
        r = '0;
        r[TGT_W-1:0] = t;
        r[PAGE_BIT]  = page;
        return r;
    endfunction

    function automatic pc_t call_dest(input logic page, input tgt_t t);
        pc_t r;
        r = '0;
        r[CALL_W-1:0] = t[CALL_W-1:0];
        r[PAGE_BIT]   = page;
        return r;
    endfunction
endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import insn_addr_pkg::*;
(
    input  strobe_t strb,
    input  pc_t     pc,
    input  logic    page,
    input  tgt_t    target,
    input  pc_t     stk_top,
    output pc_sel_e sel,
    output pc_t     nxt,
    output logic    push,
    output logic    pop,
    output pc_t     push_val
);
    always_comb begin
        if (strb.ret)       sel = SEL_RET;
        else if (strb.call) sel = SEL_CALL;
        else if (strb.jump) sel = SEL_JUMP;
        else if (strb.step) sel = SEL_STEP;
        else                sel = SEL_HOLD;
    end

    always_comb begin
        case (sel)
            SEL_RET:  nxt = stk_top;
            SEL_CALL: nxt = call_dest(page, target);
            SEL_JUMP: nxt = jump_dest(page, target);
            SEL_STEP: nxt = wrap_inc(pc);
            default:  nxt = pc;
        endcase
    end

    assign push     = (sel == SEL_CALL);
    assign pop      = (sel == SEL_RET);
    assign push_val = wrap_inc(pc);
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import insn_addr_pkg::*;
#(
    parameter int LVLS = STK_LVLS
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_val,
    output pc_t  top
);
    pc_t lvl [LVLS];

    for (genvar i = 0; i < LVLS; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl[i] <= '0;
            end else if (pop) begin
                if (i < LVLS - 1) lvl[i] <= lvl[(i < LVLS - 1) ? i + 1 : i];
            end else if (push) begin
                if (i == 0) lvl[i] <= push_val;
                else        lvl[i] <= lvl[(i > 0) ? i - 1 : 0];
            end
        end
    end

    assign top = lvl[0];

    assert_push_load_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (lvl[0] == $past(push_val)));
    assert_push_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (lvl[1] == $past(lvl[0])));
    assert_pop_keeps_bottom_R8: assert property (@(posedge clk) disable iff (rst)
        pop |=> $stable(lvl[LVLS-1]));
    assert_no_push_pop_R9: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard
    import insn_addr_pkg::*;
(
    input  pc_t   pc,
    input  logic  wr_req,
    input  phys_t wr_addr,
    output phys_t fetch_addr,
    output logic  cal_hit,
    output logic  wr_grant
);
    assign fetch_addr = pc[PHYS_W-1:0];
    assign cal_hit    = (fetch_addr == CAL_ADDR);
    assign wr_grant   = wr_req && (wr_addr != CAL_ADDR);
endmodule

// File: rtl/insn_addr_seq.sv
module insn_addr_seq
    import insn_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              page_i,
    input  logic              wr_req_i,
    input  logic [PHYS_W-1:0] wr_addr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PHYS_W-1:0] fetch_addr_o,
    output logic              cal_word_o,
    output logic              wr_grant_o
);
    pc_t     pc_q;
    pc_t     pc_nxt;
    pc_t     stk_top;
    pc_t     push_val;
    pc_sel_e sel;
    logic    push;
    logic    pop;
    strobe_t strb;

    assign strb = '{step: step_i, jump: jump_i, call: call_i, ret: ret_i};

    pc_next_sel u_sel (
        .strb     (strb),
        .pc       (pc_q),
        .page     (page_i),
        .target   (target_i),
        .stk_top  (stk_top),
        .sel      (sel),
        .nxt      (pc_nxt),
        .push     (push),
        .pop      (pop),
        .push_val (push_val)
    );

    ret_stack #(.LVLS(STK_LVLS)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    fetch_guard u_guard (
        .pc         (pc_q),
        .wr_req     (wr_req_i),
        .wr_addr    (wr_addr_i),
        .fetch_addr (fetch_addr_o),
        .cal_hit    (cal_word_o),
        .wr_grant   (wr_grant_o)
    );

    assign pc_o = pc_q;

    assert_reset_vector_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0));
    assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !jump_i && !call_i && !ret_i) |=>
        (pc_o == (($past(pc_o) + pc_t'(1)) & LOG_MASK)));
    assert_top_bit_clear_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_o[PC_W-1] == 1'b0));
    assert_ret_target_R8: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> (pc_o == $past(stk_top)));
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !jump_i && !call_i && !ret_i) |=> $stable(pc_o));
endmodule

// File: tb/insn_addr_seq_bench.sv
module insn_addr_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [8:0] target_i = '0;
    logic       page_i = 1'b0;
    logic       wr_req_i = 1'b0;
    logic [9:0] wr_addr_i = '0;
    logic [11:0] pc_o;
    logic [9:0]  fetch_addr_o;
    logic        cal_word_o;
    logic        wr_grant_o;

    int checks = 0;
    int fails  = 0;
    int m_pc = 0, m_s1 = 0, m_s2 = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    insn_addr_seq u_insn_addr_seq (
        .clk(clk), .rst(rst), .step_i(step_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .target_i(target_i), .page_i(page_i),
        .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .pc_o(pc_o),
        .fetch_addr_o(fetch_addr_o), .cal_word_o(cal_word_o),
        .wr_grant_o(wr_grant_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model, sample at next negedge
    task automatic op(input string tag, input logic r, input logic rt,
                      input logic cl, input logic jp, input logic st,
                      input int tgt, input logic pg);
        rst = r; ret_i = rt; call_i = cl; jump_i = jp; step_i = st;
        target_i = tgt[8:0]; page_i = pg;
        if (r) begin
            m_pc = 0; m_s1 = 0; m_s2 = 0;
        end else if (rt) begin
            m_pc = m_s1; m_s1 = m_s2;
        end else if (cl) begin
            m_s2 = m_s1; m_s1 = (m_pc + 1) % 2048;
            m_pc = int'(pg) * 512 + (tgt % 256);
        end else if (jp) begin
            m_pc = int'(pg) * 512 + (tgt % 512);
        end else if (st) begin
            m_pc = (m_pc + 1) % 2048;
        end
        @(negedge clk);
        chk(tag, int'(pc_o), m_pc);
        chk("R3", int'(fetch_addr_o), m_pc % 1024);
        chk("R10", int'(cal_word_o), (m_pc % 1024 == 1023) ? 1 : 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        op("R1", 1, 0, 0, 0, 0, 0, 0);
        op("R1", 0, 1, 0, 0, 0, 0, 0);                 // pop after reset -> 000h
        // full counter sweep including 7FFh -> 000h
        for (int i = 0; i < 2050; i++) op("R2", 0, 0, 0, 0, 1, 0, 0);
        // exhaustive branch targets, both pages
        for (int p = 0; p < 2; p++)
            for (int t = 0; t < 512; t++) op("R4", 0, 0, 0, 1, 0, t, p[0]);
        // call targets: bit 8 of target has no effect
        for (int t = 0; t < 512; t += 7) begin
            op("R5", 0, 0, 1, 0, 0, t, t[1]);
            op("R6", 0, 1, 0, 0, 0, 0, 0);
        end
        // overflow by three calls
        op("R4", 0, 0, 0, 1, 0, 9'h040, 0);
        op("R6", 0, 0, 1, 0, 0, 9'h011, 1);
        op("R6", 0, 0, 1, 0, 0, 9'h022, 0);
        op("R7", 0, 0, 1, 0, 0, 9'h033, 1);
        op("R7", 0, 1, 0, 0, 0, 0, 0);
        op("R7", 0, 1, 0, 0, 0, 0, 0);
        op("R8", 0, 1, 0, 0, 0, 0, 0);
        op("R8", 0, 1, 0, 0, 0, 0, 0);
        // calibration word via page 1 and via 7FFh
        op("R10", 0, 0, 0, 1, 0, 9'h1FF, 1);
        op("R12", 0, 0, 0, 0, 0, 0, 0);
        // priority combinations
        op("R9", 0, 1, 1, 1, 1, 9'h155, 1);
        op("R9", 0, 0, 1, 1, 1, 9'h1AA, 1);
        op("R9", 0, 0, 0, 1, 1, 9'h0F0, 0);
        op("R9", 1, 1, 1, 1, 1, 9'h0F0, 1);
        // mixed pseudo-random sequences
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            logic r, rt, cl, jp, st;
            string tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r  = (lfsr[5:0] == 6'h3F);
            rt = lfsr[6] & lfsr[7];
            cl = lfsr[8] & lfsr[9];
            jp = lfsr[10] & lfsr[11];
            st = lfsr[12] | lfsr[13];
            if (int'(r) + int'(rt) + int'(cl) + int'(jp) + int'(st) > 1) tg = "R9";
            else if (r)  tg = "R1";
            else if (rt) tg = "R8";
            else if (cl) tg = "R5";
            else if (jp) tg = "R4";
            else if (st) tg = "R2";
            else         tg = "R12";
            op(tg, r, rt, cl, jp, st, int'(lfsr[15:7]), lfsr[14]);
        end
        rst = 0; ret_i = 0; call_i = 0; jump_i = 0; step_i = 0;
        // write guard sweep
        for (int q = 0; q < 2; q++)
            for (int a = 0; a < 1024; a++) begin
                wr_req_i = q[0]; wr_addr_i = a[9:0];
                #1;
                chk("R11", int'(wr_grant_o), (q == 1 && a != 1023) ? 1 : 0);
            end
        wr_req_i = 0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule